// File: doc/BRIEF.md
# Binary64 Operand Class Detector

This unit inspects one 64-bit IEEE 754 double-precision operand and reports which of ten mutually exclusive categories it falls in. It cuts the word into a sign bit, an 11-bit biased exponent and a 52-bit fraction. From these fields it decides between infinities, normals, subnormals and zeros of either sign, and it separates quiet from signaling NaNs. The answer is a one-hot 10-bit mask, zero-extended onto an integer result port of width `XLEN`.

The same ten class flags, plus a combined NaN flag, also leave the block as single-bit ports. They are driven combinationally from the current operand, so a neighbouring compare or min/max unit can reuse them without decoding the operand again. The mask path either passes straight through or goes through one register stage. The parameter `REG_OUT` selects which; its default is the registered form.

Top module: `f64_class_unit`

## Requirements
- R1: An operand whose exponent field (bits 62:52) is neither all zeros nor all ones sets mask bit 1 when the sign (bit 63) is 1 and mask bit 6 when the sign is 0.
- R2: An all-ones exponent with a zero fraction (bits 51:0) sets mask bit 0 for sign 1 (negative infinity) and mask bit 7 for sign 0 (positive infinity).
- R3: A zero exponent with a nonzero fraction sets mask bit 2 for sign 1 and mask bit 5 for sign 0 (subnormals).
- R4: A zero exponent with a zero fraction sets mask bit 3 for sign 1 and mask bit 4 for sign 0 (signed zeros).
- R5: An all-ones exponent with fraction bit 51 set sets mask bit 9 (quiet NaN), whatever the sign.
- R6: An all-ones exponent with fraction bit 51 clear and a nonzero fraction sets mask bit 8 (signaling NaN), whatever the sign.
- R7: For every 64-bit operand exactly one of the ten mask bits is set.
- R8: Result bits `XLEN-1` down to 10 are always zero.
- R9: With `REG_OUT`=1, the mask for an operand presented with `in_valid` high appears on `class_x`, together with `out_valid` high, one clock edge later. After reset, `out_valid` and `class_x` are zero.
- R10: With `REG_OUT`=1, a cycle with `in_valid` low leaves `class_x` unchanged and drives `out_valid` low on the next edge, even if the operand changes.
- R11: The eleven flag outputs follow the current operand in the same cycle. Each class flag equals its mask bit, and `nan_o` is the OR of the two NaN flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand qualifier |
| operand | input | 64 | Binary64 operand |
| out_valid | output | 1 | Result qualifier |
| class_x | output | XLEN | Zero-extended one-hot class mask |
| ninf_o | output | 1 | Negative infinity |
| nnorm_o | output | 1 | Negative normal |
| nsub_o | output | 1 | Negative subnormal |
| nzero_o | output | 1 | Negative zero |
| pzero_o | output | 1 | Positive zero |
| psub_o | output | 1 | Positive subnormal |
| pnorm_o | output | 1 | Positive normal |
| pinf_o | output | 1 | Positive infinity |
| snan_o | output | 1 | Signaling NaN |
| qnan_o | output | 1 | Quiet NaN |
| nan_o | output | 1 | Either NaN |

## Verification
The flag ports have no register in their path, so the bench reads them 1 ns after it drives an operand on a falling edge. The mask and `out_valid` pass through one register in the default build, so they are due one rising edge after the operand. The bench reads them on the falling edge that follows that rising edge, one full cycle after driving. For the hold scenario the bench lowers `in_valid`, changes the operand, and checks on the next two falling edges that the mask still holds the earlier class and `out_valid` is low.

// File: rtl/f64cls_pkg.sv
`timescale 1ns/1ps
package f64cls_pkg;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned FP_W   = 1 + EXP_W + FRAC_W;
  localparam int unsigned CLS_W  = 10;

  // Mask bit positions; the order is architecturally visible.
  localparam int unsigned C_NINF  = 0;
  localparam int unsigned C_NNORM = 1;
  localparam int unsigned C_NSUB  = 2;
  localparam int unsigned C_NZERO = 3;
  localparam int unsigned C_PZERO = 4;
  localparam int unsigned C_PSUB  = 5;
  localparam int unsigned C_PNORM = 6;
  localparam int unsigned C_PINF  = 7;
  localparam int unsigned C_SNAN  = 8;
  localparam int unsigned C_QNAN  = 9;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } fp_fields_t;
endpackage

// File: rtl/f64cls_split.sv
`timescale 1ns/1ps
module f64cls_split
  import f64cls_pkg::*;
(
  input  logic [FP_W-1:0] word_i,
  output fp_fields_t      fld_o,
  output logic            exp_max_o,
  output logic            exp_min_o,
  output logic            frac_nz_o
);
  always_comb begin
    fld_o.sign = word_i[FP_W-1];
    fld_o.expo = word_i[FP_W-2 -: EXP_W];
    fld_o.frac = word_i[FRAC_W-1:0];
  end

  assign exp_max_o = &fld_o.expo;
  assign exp_min_o = ~|fld_o.expo;
  assign frac_nz_o = |fld_o.frac;
endmodule

// File: rtl/f64cls_pred.sv
`timescale 1ns/1ps
module f64cls_pred
  import f64cls_pkg::*;
(
  input  fp_fields_t       fld_i,
  input  logic             exp_max_i,
  input  logic             exp_min_i,
  input  logic             frac_nz_i,
  output logic [CLS_W-1:0] cls_o
);
  logic quiet_bit;
  logic is_norm, is_inf, is_sub, is_zero;

  assign quiet_bit = fld_i.frac[FRAC_W-1];
  assign is_norm   = !exp_max_i && !exp_min_i;
  assign is_inf    = exp_max_i && !frac_nz_i;
  assign is_sub    = exp_min_i && frac_nz_i;
  assign is_zero   = exp_min_i && !frac_nz_i;

  always_comb begin
    cls_o          = '0;
    cls_o[C_NINF]  = is_inf  &&  fld_i.sign;
    cls_o[C_NNORM] = is_norm &&  fld_i.sign;
    cls_o[C_NSUB]  = is_sub  &&  fld_i.sign;
    cls_o[C_NZERO] = is_zero &&  fld_i.sign;
    cls_o[C_PZERO] = is_zero && !fld_i.sign;
    cls_o[C_PSUB]  = is_sub  && !fld_i.sign;
    cls_o[C_PNORM] = is_norm && !fld_i.sign;
    cls_o[C_PINF]  = is_inf  && !fld_i.sign;
    cls_o[C_SNAN]  = exp_max_i && !quiet_bit && frac_nz_i;
    cls_o[C_QNAN]  = exp_max_i && quiet_bit;
  end
endmodule

// File: rtl/f64cls_stage.sv
`timescale 1ns/1ps
module f64cls_stage #(
  parameter int unsigned W       = 10,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q_r, q_nx;
      logic         v_r, v_nx;

      always_comb begin
        v_nx = vld_i;
        q_nx = q_r;
        if (vld_i) q_nx = d_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
          v_r <= 1'b0;
        end else begin
          q_r <= q_nx;
          v_r <= v_nx;
        end
      end

      assign q_o   = q_r;
      assign vld_o = v_r;

      p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
      p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (q_o == $past(d_i)));
      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(q_o) && !vld_o));
    end else begin : g_comb
      assign q_o   = d_i;
      assign vld_o = vld_i;
    end
  endgenerate
endmodule

// File: rtl/f64_class_unit.sv
`timescale 1ns/1ps
module f64_class_unit
  import f64cls_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [FP_W-1:0] operand,
  output logic            out_valid,
  output logic [XLEN-1:0] class_x,
  output logic            ninf_o,
  output logic            nnorm_o,
  output logic            nsub_o,
  output logic            nzero_o,
  output logic            pzero_o,
  output logic            psub_o,
  output logic            pnorm_o,
  output logic            pinf_o,
  output logic            snan_o,
  output logic            qnan_o,
  output logic            nan_o
);
  localparam int unsigned PAD_W = XLEN - CLS_W;

  fp_fields_t       fld;
  logic             exp_max, exp_min, frac_nz;
  logic [CLS_W-1:0] cls_now, cls_out;

  f64cls_split u_split (
    .word_i    (operand),
    .fld_o     (fld),
    .exp_max_o (exp_max),
    .exp_min_o (exp_min),
    .frac_nz_o (frac_nz)
  );

  f64cls_pred u_pred (
    .fld_i     (fld),
    .exp_max_i (exp_max),
    .exp_min_i (exp_min),
    .frac_nz_i (frac_nz),
    .cls_o     (cls_now)
  );

  f64cls_stage #(.W(CLS_W), .REG_OUT(REG_OUT)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .d_i   (cls_now),
    .vld_o (out_valid),
    .q_o   (cls_out)
  );

  assign class_x = {{PAD_W{1'b0}}, cls_out};

  assign ninf_o  = cls_now[C_NINF];
  assign nnorm_o = cls_now[C_NNORM];
  assign nsub_o  = cls_now[C_NSUB];
  assign nzero_o = cls_now[C_NZERO];
  assign pzero_o = cls_now[C_PZERO];
  assign psub_o  = cls_now[C_PSUB];
  assign pnorm_o = cls_now[C_PNORM];
  assign pinf_o  = cls_now[C_PINF];
  assign snan_o  = cls_now[C_SNAN];
  assign qnan_o  = cls_now[C_QNAN];
  assign nan_o   = cls_now[C_SNAN] | cls_now[C_QNAN];

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(cls_now) == 1));
  p_nan_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (nan_o == (exp_max && frac_nz)));
  p_out_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(cls_out) && (cls_out != '0));
endmodule

// File: tb/f64_class_unit_tb.sv
`timescale 1ns/1ps
module f64_class_unit_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [63:0]     operand;
  logic            out_valid;
  logic [XLEN-1:0] class_x;
  logic ninf_o, nnorm_o, nsub_o, nzero_o, pzero_o, psub_o, pnorm_o, pinf_o;
  logic snan_o, qnan_o, nan_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] last_exp;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  f64_class_unit #(.XLEN(XLEN), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .out_valid(out_valid), .class_x(class_x),
    .ninf_o(ninf_o), .nnorm_o(nnorm_o), .nsub_o(nsub_o), .nzero_o(nzero_o),
    .pzero_o(pzero_o), .psub_o(psub_o), .pnorm_o(pnorm_o), .pinf_o(pinf_o),
    .snan_o(snan_o), .qnan_o(qnan_o), .nan_o(nan_o)
  );

  // Expected class from the requirement text.
  function automatic logic [63:0] want(input logic [63:0] v);
    logic s; logic [10:0] e; logic [51:0] f;
    logic [63:0] m;
    s = v[63]; e = v[62:52]; f = v[51:0];
    m = 64'd0;
    if (e == 11'h7FF) begin
      if (f == 52'd0) m = s ? 64'd1 : 64'd128;
      else if (f[51]) m = 64'd512;
      else            m = 64'd256;
    end else if (e == 11'd0) begin
      if (f == 52'd0) m = s ? 64'd8 : 64'd16;
      else            m = s ? 64'd4 : 64'd32;
    end else begin
      m = s ? 64'd2 : 64'd64;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] flag_vec();
    return {53'd0, nan_o, qnan_o, snan_o, pinf_o, pnorm_o, psub_o,
            pzero_o, nzero_o, nsub_o, nnorm_o, ninf_o};
  endfunction

  // Drive on a falling edge, flags read 1 ns later, mask read one cycle later.
  task automatic apply(input string req, input logic [63:0] v);
    logic [63:0] m;
    m = want(v);
    @(negedge clk);
    in_valid = 1'b1;
    operand  = v;
    #1;
    check("R11 flags", flag_vec(), {53'd0, m[8] | m[9], m[9:0]});
    @(negedge clk);
    check(req, class_x, m);
    check("R9 out_valid", {63'd0, out_valid}, 64'd1);
    last_exp = m;
  endtask

  function automatic logic [63:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  task automatic t_reset();
    check("R9 reset mask", class_x, 64'd0);
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_normals();
    apply("R1 +1.0", 64'h3FF0_0000_0000_0000);
    apply("R1 -2.5", 64'hC004_0000_0000_0000);
    apply("R1 min exp", 64'h0010_0000_0000_0000);
    apply("R1 max exp", 64'hFFEF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_inf();
    apply("R2 +inf", 64'h7FF0_0000_0000_0000);
    apply("R2 -inf", 64'hFFF0_0000_0000_0000);
  endtask

  task automatic t_sub();
    apply("R3 +sub lsb", 64'h0000_0000_0000_0001);
    apply("R3 -sub msb", 64'h8008_0000_0000_0000);
  endtask

  task automatic t_zero();
    apply("R4 +0", 64'h0000_0000_0000_0000);
    apply("R4 -0", 64'h8000_0000_0000_0000);
  endtask

  task automatic t_qnan();
    apply("R5 qnan +", 64'h7FF8_0000_0000_0000);
    apply("R5 qnan -", 64'hFFF8_0000_0000_0001);
    check("R5 class bit 9", class_x, 64'd512);
  endtask

  task automatic t_snan();
    apply("R6 snan + lsb", 64'h7FF0_0000_0000_0001);
    apply("R6 snan -", 64'hFFF4_0000_0000_0000);
    check("R6 class bit 8", class_x, 64'd256);
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      logic [63:0] v;
      v = rnd();
      case (i % 4)
        1: v[62:52] = 11'h7FF;
        2: v[62:52] = 11'h000;
        default: ;
      endcase
      apply("R7 random", v);
      check("R7 one-hot", {63'd0, $countones(class_x[9:0]) == 1}, 64'd1);
      check("R8 upper zero", {10'd0, class_x[63:10]}, 64'd0);
    end
  endtask

  task automatic t_hold();
    logic [63:0] keep;
    apply("R10 setup", 64'h4000_0000_0000_0000);
    keep = last_exp;
    @(negedge clk);
    in_valid = 1'b0;
    operand  = 64'hFFF0_0000_0000_0000;
    @(negedge clk);
    check("R10 hold mask", class_x, keep);
    check("R10 valid low", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R10 hold mask 2", class_x, keep);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    operand  = 64'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normals();
    t_inf();
    t_sub();
    t_zero();
    t_qnan();
    t_snan();
    t_hold();
    t_random();
    @(negedge clk);
    in_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule